// File: doc/BRIEF.md
# Ping-Pong Raster Line Buffer

This block stores two raster lines of rendered pixels in one memory split into two equal halves. A renderer fills the next line into the write half while the video output stage fetches the last completed line from the display half through a 12-bit read address, receiving 9-bit pixels one clock later.

The renderer never swaps the halves itself. It raises a line-complete pulse, and the exchange is deferred to the next sync/flyback strobe. If no line has been completed since the previous exchange, the strobe leaves the halves alone and the display shows the old line again. A partially rendered line therefore never reaches the screen, and the picture cannot tear within a line.

Top module: `line_pingpong_buf`

## Requirements
- R1: While `rst` is high, `rd_data` is driven to 0, the write half is half 0 (top address bit 0), the display half is half 1, and no line-complete is pending.
- R2: `rd_data` returns the entry at {display half, `rd_addr[10:0]`}, registered, in the cycle after the address is presented.
- R3: `rd_addr[11]` has no effect on the entry read.
- R4: A write with `wr_en` high stores `wr_data` at {write half, `wr_addr`}. The display half, and so `rd_data`, is unchanged until a swap.
- R5: A swap exchanges the two halves at a clock edge where `sync_strobe` is high and a line-complete is pending. A `sync_strobe` with nothing pending leaves the halves as they are, so the same line is shown again.
- R6: `line_done` without `sync_strobe` never swaps. Several `line_done` pulses between two strobes count as one pending line, and the pending state is cleared by the swap.
- R7: `line_done` and `sync_strobe` high in the same cycle cause a swap in that cycle.
- R8: A write in the swap cycle lands in the new write half, which is the half that was displayed before the swap.
- R9: A read presented in the swap cycle returns data from the display half in effect before the swap. When the same entry is written in that cycle, the read returns the content that entry had before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the renderer |
| wr_addr | input | 11 | Pixel index within the write half |
| wr_data | input | 9 | Pixel value to store |
| line_done | input | 1 | Renderer marks the write half as a finished line |
| sync_strobe | input | 1 | Horizontal sync / flyback moment when an exchange is allowed |
| rd_addr | input | 12 | Display read address; only the low 11 bits are used |
| rd_data | output | 9 | Registered pixel, valid one cycle after `rd_addr` |

## Verification
The exchange of halves can coincide with a renderer write, with a display read, and with a fresh `line_done`. The bench provokes all three in one clock: it arms a pending line and then, in the strobe cycle, drives a write and a read at the same pixel index. It judges that cycle by reading the pre-swap line in the next cycle, by finding the written value missing from the newly shown line, and by finding it present once the following swap brings that half back to the display. A behavioural model tracks every cycle of long sweeps in which line writes run under mid-line strobes, so a line mixing old and new pixels would show up as a mismatch.

// File: rtl/lpb_pkg.sv
package lpb_pkg;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  function automatic half_e flip_half(half_e h);
    return (h == HALF_LO) ? HALF_HI : HALF_LO;
  endfunction

endpackage

// File: rtl/lpb_bank_ctrl.sv
module lpb_bank_ctrl
  import lpb_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sync_strobe,
  input  logic  line_done,
  output half_e wr_half,
  output logic  pend,
  output logic  swap_now
);

  // an exchange needs the strobe plus a finished line (held or arriving now)
  always_comb swap_now = sync_strobe & (pend | line_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_half <= HALF_LO;
      pend    <= 1'b0;
    end else if (swap_now) begin
      wr_half <= flip_half(wr_half);
      pend    <= 1'b0;
    end else if (line_done) begin
      pend    <= 1'b1;
    end
  end

endmodule

// File: rtl/lpb_ram.sv
module lpb_ram #(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // write port, no reset so the array maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read, read-before-write on a shared address
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

endmodule

// File: rtl/line_pingpong_buf.sv
module line_pingpong_buf
  import lpb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-2:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_done,
  input  logic              sync_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int LOW_W = ADDR_W - 1;

  half_e wr_half;
  half_e wr_target;
  half_e disp_half;
  logic  pend;
  logic  swap_now;

  logic [ADDR_W-1:0] ram_waddr;
  logic [ADDR_W-1:0] ram_raddr;

  lpb_bank_ctrl u_bank (
    .clk         (clk),
    .rst         (rst),
    .sync_strobe (sync_strobe),
    .line_done   (line_done),
    .wr_half     (wr_half),
    .pend        (pend),
    .swap_now    (swap_now)
  );

  always_comb begin
    // a write in the exchange cycle already belongs to the next line
    wr_target = swap_now ? flip_half(wr_half) : wr_half;
    disp_half = flip_half(wr_half);
    ram_waddr = {wr_target, wr_addr};
    ram_raddr = {disp_half, rd_addr[LOW_W-1:0]};
  end

  lpb_ram #(
    .AW (ADDR_W),
    .DW (DATA_W)
  ) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (ram_waddr),
    .wdata (wr_data),
    .raddr (ram_raddr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/lpb_checker.sv
module lpb_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_strobe,
  input logic              line_done,
  input logic              wr_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_half,
  input logic              pend,
  input logic              swap_now
);

  localparam int LOW_W = ADDR_W - 1;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && wr_half == 1'b0 && !pend)); // R1

  AST_TOP_BIT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && !$past(swap_now)
     && rd_addr[LOW_W-1:0] == $past(rd_addr[LOW_W-1:0])
     && rd_addr[ADDR_W-1] != $past(rd_addr[ADDR_W-1]))
    |=> rd_data == $past(rd_data)); // R3

  AST_HOLD_WITHOUT_SYNC: assert property (@(posedge clk) disable iff (rst)
    !sync_strobe |=> wr_half == $past(wr_half)); // R5

  AST_SYNC_NOTHING_PENDING: assert property (@(posedge clk) disable iff (rst)
    (sync_strobe && !pend && !line_done) |=> wr_half == $past(wr_half)); // R5

  AST_SWAP_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    (sync_strobe && (pend || line_done)) |=> wr_half != $past(wr_half)); // R7

  AST_DONE_ARMS: assert property (@(posedge clk) disable iff (rst)
    (line_done && !sync_strobe) |=> pend); // R6

  AST_SWAP_CONSUMES: assert property (@(posedge clk) disable iff (rst)
    swap_now |=> !pend); // R6

endmodule

bind line_pingpong_buf lpb_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sync_strobe (sync_strobe),
  .line_done   (line_done),
  .wr_en       (wr_en),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .wr_half     (wr_half),
  .pend        (pend),
  .swap_now    (swap_now)
);

// File: tb/sim_line_pingpong_buf.sv
`timescale 1ns/1ps
module sim_line_pingpong_buf;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 9;
  localparam int LOW_W  = ADDR_W - 1;
  localparam int HALF_N = 1 << LOW_W;
  localparam int TOTAL  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [LOW_W-1:0]  wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              line_done = 1'b0;
  logic              sync_strobe = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;

  always #2.5 clk = ~clk;

  line_pingpong_buf u0 (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .line_done (line_done), .sync_strobe (sync_strobe),
    .rd_addr (rd_addr), .rd_data (rd_data)
  );

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  // behavioural reference: plain array, half flag, pending flag
  logic [DATA_W-1:0] m_mem [TOTAL];
  bit                m_known [TOTAL];
  bit                m_wb = 1'b0;
  bit                m_pend = 1'b0;
  logic [DATA_W-1:0] m_exp = '0;
  bit                m_exp_ok = 1'b0;

  always @(posedge clk) begin : ref_model
    int ra;
    int wa;
    bit sw;
    if (rst) begin
      m_wb = 1'b0; m_pend = 1'b0; m_exp = '0; m_exp_ok = 1'b1;
    end else begin
      ra = ((m_wb ? 0 : 1) << LOW_W) + int'(rd_addr[LOW_W-1:0]);
      m_exp = m_mem[ra];
      m_exp_ok = m_known[ra];
      sw = sync_strobe && (m_pend || line_done);
      if (wr_en) begin
        wa = (((sw ? !m_wb : m_wb) ? 1 : 0) << LOW_W) + int'(wr_addr);
        m_mem[wa] = wr_data;
        m_known[wa] = 1'b1;
      end
      if (sw) begin
        m_wb = !m_wb; m_pend = 1'b0;
      end else if (line_done) begin
        m_pend = 1'b1;
      end
    end
  end

  task automatic check(bit ok, string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: rd_data actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished && m_exp_ok) check(rd_data === m_exp, cur_req, rd_data, m_exp);
  end

  function automatic logic [DATA_W-1:0] pat(int line, int i);
    return DATA_W'((line * 97 + i * 13 + 3) % 512);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_line(int line, bit sweep);
    for (int i = 0; i < HALF_N; i++) begin
      wr_en = 1'b1;
      wr_addr = LOW_W'(i);
      wr_data = pat(line, i);
      if (sweep) begin
        rd_addr = ADDR_W'((i * 7) % HALF_N);
        sync_strobe = ((i % 300) == 150);
      end
      tick();
    end
    wr_en = 1'b0;
    sync_strobe = 1'b0;
  endtask

  task automatic pulse_done();
    line_done = 1'b1; tick(); line_done = 1'b0;
  endtask

  task automatic pulse_sync();
    sync_strobe = 1'b1; tick(); sync_strobe = 1'b0;
  endtask

  task automatic rd_check(int a, logic [DATA_W-1:0] v, string req);
    rd_addr = ADDR_W'(a);
    tick();
    check(rd_data === v, req, rd_data, v);
  endtask

  initial begin
    repeat (4) tick();
    check(rd_data === '0, "R1", rd_data, '0);
    rst = 1'b0;

    // first line, then publish it
    cur_req = "R4";
    write_line(1, 1'b0);
    pulse_done();
    pulse_sync();
    cur_req = "R2";
    rd_check(0, pat(1, 0), "R2");
    rd_check(HALF_N - 1, pat(1, HALF_N - 1), "R2");
    rd_check(100, pat(1, 100), "R2");

    // second line rendered while the first is shown
    cur_req = "R4";
    write_line(2, 1'b1);
    rd_check(5, pat(1, 5), "R4");

    cur_req = "R6";
    pulse_done();
    pulse_done();
    rd_check(7, pat(1, 7), "R6");

    cur_req = "R3";
    rd_check(HALF_N | 9, pat(1, 9), "R3");
    rd_check(TOTAL - 1, pat(1, HALF_N - 1), "R3");

    cur_req = "R5";
    pulse_sync();
    rd_check(9, pat(2, 9), "R5");
    pulse_sync();
    rd_check(9, pat(2, 9), "R5");
    rd_check(11, pat(2, 11), "R6");

    cur_req = "R7";
    line_done = 1'b1; sync_strobe = 1'b1;
    tick();
    line_done = 1'b0; sync_strobe = 1'b0;
    rd_check(9, pat(1, 9), "R7");

    // write and read the same pixel in the exchange cycle
    cur_req = "R9";
    pulse_done();
    sync_strobe = 1'b1; wr_en = 1'b1; wr_addr = LOW_W'(5); wr_data = 9'h1AB;
    rd_addr = ADDR_W'(5);
    tick();
    sync_strobe = 1'b0; wr_en = 1'b0;
    check(rd_data === pat(1, 5), "R9", rd_data, pat(1, 5));
    cur_req = "R8";
    rd_check(5, pat(2, 5), "R8");
    pulse_done();
    pulse_sync();
    rd_check(5, 9'h1AB, "R8");
    rd_check(6, pat(1, 6), "R8");

    // tearing sweeps: strobes inside each line with nothing pending
    cur_req = "R4";
    for (int l = 3; l < 6; l++) begin
      write_line(l, 1'b1);
      pulse_done();
      pulse_sync();
      rd_check(20, pat(l, 20), "R5");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule